// File: doc/BRIEF.md
# PHY Status Change Latch

This block watches nine status levels coming from a PHY and keeps a readable copy of them. The levels arrive asynchronously, so each one passes through a two-stage synchronizer. While no change is waiting to be read, each bit of the copy follows its input. When a synchronized input moves, the new level is captured, the bit freezes, and a change-interrupt request goes up towards the interrupt controller.

A read strobe returns the held word in the same cycle. On the next clock edge the whole word is loaded with the current synchronized levels and detection is re-armed. If that read edge finds a level that differs from the value just read, the change is not lost: the bit is captured again and the request is raised again. The interrupt request does not clear on a read. It stays high until a separate acknowledge pulse arrives.

Top module: `phyChangeStatus`

## Requirements
- R1: After reset is released and the synchronizer has filled (within 5 cycles), the read data equals the input levels and the interrupt request is low. No change is flagged for levels that were already present during reset.
- R2: A level change on any input bit is captured into the read data and sets the interrupt request. Several bits changing together are all captured. Bit order: 0 link fail, 1 loss of sync, 2 codeword error, 3 start-of-stream error, 4 end-of-stream error, 5 polarity reversal, 6 jabber, 7 speed detect, 8 duplex detect.
- R3: Once a bit has captured a change, further movement of that input does not alter the bit until a read. Other bits that have not captured a change still capture their own changes.
- R4: While the read strobe is high, the read data in that same cycle is the held word.
- R5: On the edge that ends a read cycle, the held word is loaded with the current synchronized levels. A later read with no intervening change returns those levels and raises no request.
- R6: If a synchronized level differs from the held bit on a read edge, that bit is captured again and the interrupt request is set.
- R7: The interrupt request stays high across cycles and across reads until an acknowledge pulse arrives.
- R8: An acknowledge pulse clears the interrupt request on the next edge, unless a capture happens on that same edge, in which case the request stays high.
- R9: An input change reaches the read data on the third rising edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusIn | input | 9 | Asynchronous PHY status levels, bit order as in R2 |
| rdStrobe | input | 1 | Read strobe, one cycle per read |
| ackStrobe | input | 1 | Interrupt acknowledge pulse |
| rdData | output | 9 | Held status word |
| changeIrq | output | 1 | Change-interrupt request |

## Verification
On every cycle, the assertions check how the request flag moves: it is set by a capture, it holds without an acknowledge, it clears after an acknowledge with no capture, and it stays quiet while the synchronizer fills. They also check that captured bits stay frozen between reads and that a read loads the live levels. Some results can only be shown by the bench scenarios, because they depend on where a stimulus falls in time. These are the three-edge latency of a change, a change that lands exactly on the read edge, an acknowledge that collides with a capture, and levels that were present during reset.

// File: rtl/chgstat_pkg.sv
`timescale 1ns/1ps
package chgstat_pkg;
  localparam int STAT_W     = 9;
  localparam int SYNC_DEPTH = 2;

  localparam int LINK_FAIL_BIT  = 0;
  localparam int SYNC_LOSS_BIT  = 1;
  localparam int CODE_ERR_BIT   = 2;
  localparam int SOS_ERR_BIT    = 3;
  localparam int EOS_ERR_BIT    = 4;
  localparam int POL_REV_BIT    = 5;
  localparam int JABBER_BIT     = 6;
  localparam int SPEED_BIT      = 7;
  localparam int DUPLEX_BIT     = 8;

  typedef struct packed {
    logic primeLoad;
    logic readRefresh;
  } dpCtrl_t;
endpackage

// File: rtl/chgstat_sync.sv
`timescale 1ns/1ps
module chgstat_sync #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/chgstat_datapath.sv
`timescale 1ns/1ps
module chgstat_datapath
  import chgstat_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctl,
  input  logic [W-1:0] syncVal,
  output logic [W-1:0] heldWord,
  output logic [W-1:0] pendMask,
  output logic         captureAny
);
  logic [W-1:0] captureMask;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic heldB, pendB, diffB;
    assign diffB = syncVal[b] ^ heldB;
    assign captureMask[b] = !ctl.primeLoad && diffB && (ctl.readRefresh || !pendB);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        heldB <= 1'b0;
        pendB <= 1'b0;
      end else if (ctl.primeLoad) begin
        heldB <= syncVal[b];
        pendB <= 1'b0;
      end else if (ctl.readRefresh) begin
        heldB <= syncVal[b];
        pendB <= diffB;
      end else if (captureMask[b]) begin
        heldB <= syncVal[b];
        pendB <= 1'b1;
      end
    end

    assign heldWord[b] = heldB;
    assign pendMask[b] = pendB;
  end

  assign captureAny = |captureMask;
endmodule

// File: rtl/chgstat_ctrl.sv
`timescale 1ns/1ps
module chgstat_ctrl
  import chgstat_pkg::*;
#(
  parameter int DEPTH = SYNC_DEPTH
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rdStrobe,
  input  logic    ackStrobe,
  input  logic    captureAny,
  output dpCtrl_t ctl,
  output logic    irq
);
  localparam int CW = $clog2(DEPTH + 2);
  localparam logic [CW-1:0] PRIME_LAST = CW'(DEPTH);

  logic [CW-1:0] settleCnt;
  logic          priming;

  assign priming = (settleCnt <= PRIME_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      irq       <= 1'b0;
    end else begin
      if (priming) settleCnt <= settleCnt + 1'b1;
      if (captureAny)     irq <= 1'b1;
      else if (ackStrobe) irq <= 1'b0;
    end
  end

  always_comb begin
    ctl.primeLoad   = priming;
    ctl.readRefresh = rdStrobe && !priming;
  end
endmodule

// File: rtl/phyChangeStatus.sv
`timescale 1ns/1ps
module phyChangeStatus
  import chgstat_pkg::*;
#(
  parameter int W     = STAT_W,
  parameter int DEPTH = SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] statusIn,
  input  logic         rdStrobe,
  input  logic         ackStrobe,
  output logic [W-1:0] rdData,
  output logic         changeIrq
);
  dpCtrl_t      dpCtl;
  logic [W-1:0] syncLive;
  logic [W-1:0] pendMask;
  logic         captureAny;

  chgstat_sync #(.W(W), .DEPTH(DEPTH)) u_sync (
    .clk(clk), .rstN(rstN), .din(statusIn), .dout(syncLive)
  );

  chgstat_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .syncVal(syncLive),
    .heldWord(rdData), .pendMask(pendMask), .captureAny(captureAny)
  );

  chgstat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .ackStrobe(ackStrobe),
    .captureAny(captureAny), .ctl(dpCtl), .irq(changeIrq)
  );
endmodule

// File: rtl/chgstat_checker.sv
`timescale 1ns/1ps
module chgstat_checker #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rstN,
  input logic         rdStrobe,
  input logic         ackStrobe,
  input logic         changeIrq,
  input logic [W-1:0] rdData,
  input logic [W-1:0] syncLive,
  input logic [W-1:0] pendMask,
  input logic         captureAny,
  input logic         primeLoad
);
  p_quiet_prime_r1: assert property (@(posedge clk) disable iff (!rstN)
    primeLoad |-> !changeIrq);

  p_capture_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    captureAny |=> changeIrq);

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe && !primeLoad) |=>
      ((rdData & $past(pendMask)) == ($past(rdData) & $past(pendMask))));

  p_refresh_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !primeLoad) |=> (rdData == $past(syncLive)));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (changeIrq && !ackStrobe) |=> changeIrq);

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !captureAny) |=> !changeIrq);
endmodule

bind phyChangeStatus chgstat_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .ackStrobe(ackStrobe),
  .changeIrq(changeIrq), .rdData(rdData), .syncLive(syncLive),
  .pendMask(pendMask), .captureAny(captureAny), .primeLoad(dpCtl.primeLoad)
);

// File: tb/phyChangeStatus_test.sv
`timescale 1ns/1ps
module phyChangeStatus_test;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] statusIn = 9'h0A5;
  logic         rdStrobe = 1'b0;
  logic         ackStrobe = 1'b0;
  logic [W-1:0] rdData;
  logic         changeIrq;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [W-1:0] expData;
    string        tag;
  } readItem_t;
  readItem_t expQ[$];

  always #10 clk = ~clk;

  phyChangeStatus uut (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .rdStrobe(rdStrobe),
    .ackStrobe(ackStrobe), .rdData(rdData), .changeIrq(changeIrq)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic checkVal(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one-cycle read, expected word queued for the monitor
  task automatic doRead(input logic [W-1:0] exp, input string tag);
    readItem_t it;
    it.expData = exp;
    it.tag     = tag;
    expQ.push_back(it);
    rdStrobe = 1'b1;
    waitCyc(1);
    rdStrobe = 1'b0;
  endtask

  task automatic pulseAck();
    ackStrobe = 1'b1;
    waitCyc(1);
    ackStrobe = 1'b0;
  endtask

  // Monitor: samples the read data mid-cycle while the strobe is high
  initial begin
    forever begin
      @(negedge clk);
      if (rdStrobe) begin
        if (expQ.size() == 0) begin
          nChecks++;
          nFails++;
          $display("FAIL R4: read with empty queue, actual %h expected none", rdData);
        end else begin
          readItem_t it;
          it = expQ.pop_front();
          checkVal(it.tag, rdData, it.expData);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(5);
    // R1: levels present through reset load with no flag
    checkVal("R1 irq after reset", {8'h0, changeIrq}, 9'h0);
    doRead(9'h0A5, "R1/R4 read after reset");
    waitCyc(1);
    checkVal("R5 no request after quiet read", {8'h0, changeIrq}, 9'h0);

    // R9 latency, R2 capture on bit 0 (link fail)
    statusIn = 9'h0A4;
    waitCyc(1);
    checkVal("R9 edge1 unchanged", rdData, 9'h0A5);
    waitCyc(1);
    checkVal("R9 edge2 unchanged", rdData, 9'h0A5);
    waitCyc(1);
    checkVal("R9/R2 edge3 captured", rdData, 9'h0A4);
    checkVal("R2 request set", {8'h0, changeIrq}, 9'h1);

    // R3: frozen bit ignores further change, other bit still captures
    statusIn = 9'h0A5;
    waitCyc(5);
    checkVal("R3 frozen bit holds", rdData, 9'h0A4);
    statusIn = 9'h1A5;
    waitCyc(5);
    checkVal("R3/R2 other bit captures", rdData, 9'h1A4);

    // R4/R5/R6/R7: read, refresh, re-capture of bit 0, request survives reads
    doRead(9'h1A4, "R4 read frozen word");
    doRead(9'h1A5, "R5 read refreshed word");
    checkVal("R7 request survives reads", {8'h0, changeIrq}, 9'h1);
    waitCyc(4);
    checkVal("R7 request holds", {8'h0, changeIrq}, 9'h1);

    // R8: acknowledge clears
    pulseAck();
    checkVal("R8 ack clears", {8'h0, changeIrq}, 9'h0);
    doRead(9'h1A5, "R5 quiet read");
    waitCyc(2);
    checkVal("R5 no request after quiet read 2", {8'h0, changeIrq}, 9'h0);

    // R6: change reaches synchronizer output on the read edge
    statusIn = 9'h1A7;
    waitCyc(2);
    doRead(9'h1A5, "R6 read before change lands");
    checkVal("R6 request set on read edge", {8'h0, changeIrq}, 9'h1);
    doRead(9'h1A7, "R6 new level read");

    // R8: acknowledge colliding with a capture keeps request
    pulseAck();
    checkVal("R8 ack clears again", {8'h0, changeIrq}, 9'h0);
    statusIn = 9'h187;
    waitCyc(2);
    pulseAck();
    checkVal("R8 capture beats ack", {8'h0, changeIrq}, 9'h1);
    doRead(9'h187, "R2 polarity bit read");

    // R2: all bits change together
    pulseAck();
    statusIn = 9'h078;
    waitCyc(5);
    checkVal("R2 multi-bit request", {8'h0, changeIrq}, 9'h1);
    doRead(9'h078, "R2 multi-bit read");
    doRead(9'h078, "R5 multi-bit settled");

    waitCyc(2);
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R4: reads left unchecked actual %0d expected 0", expQ.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule